// File: doc/BRIEF.md
# Cache Line Fill Read Sequencer

This block is the processor-side bus engine that fetches one cache line over a 64-bit external data bus using non-pipelined read cycles. A line fill request enters on a valid/ready handshake. The sequencer then runs one bus cycle. In the address clock it asserts an active-low start strobe and an active-low cache-request output, and it drives the line address. It holds that address until the cycle ends. It then waits for the active-low ready input. If the cacheability input is negated at the first ready, the cycle ends as a single transfer. If it is asserted, the cycle becomes a four-beat burst, and ready is counted on every later clock until four beats have arrived.

Each captured beat is checked for even parity per byte. A failing beat produces a one-clock low pulse on an active-low parity-error output, two clocks after the ready that delivered it. When the last beat is in, the assembled line comes out with a one-clock strobe. The line carries a flag for a single transfer and a flag giving the line policy: exclusive (writeback) or shared. Beats are placed in interleaved order, derived from the starting address. The request handshake is the only back-pressure point. A request is taken only while the sequencer is idle. The line output has no ready input, and the consumer must take the line in the strobe clock.

Top module: `burst_seq`

## Requirements
- R1: `req_ready` is high only while idle. A request accepted (`req_valid` and `req_ready` high at an edge) makes `bus_start_n` and `bus_cache_req_n` low for exactly the next clock, with `bus_addr` equal to the accepted `req_addr`.
- R2: `bus_addr` stays stable from the address clock through the clock that delivers the final beat.
- R3: `bus_rdy_n` is ignored during the address clock. It is first sampled at the end of the clock after that. Every clock with `bus_rdy_n` high, before any beat, adds a wait state.
- R4: If `bus_cacheable_n` is high at the first sampled ready, the cycle ends after one beat. `line_single` is 1, the beat lies in slot `req_addr[4:3]`, and every other slot is zero.
- R5: If `bus_cacheable_n` is low at the first sampled ready, the cycle takes four readies in total. Wait states may fall between them. `bus_cacheable_n` at later readies has no effect.
- R6: Beat k (k = 0..3, in arrival order) goes to slot `req_addr[4:3] XOR k`. Slot s occupies `line_data[64*s +: 64]`.
- R7: `line_valid` is a one-clock pulse in the clock after the final beat is captured, and `req_ready` is high in that same clock.
- R8: `line_excl` is 1 when `bus_wbpol` was 1 at the first sampled ready and `req_pwt` was 0 at acceptance. Otherwise it is 0. `bus_wbpol` at later readies has no effect.
- R9: Byte i of `bus_data` with `bus_dpar[i]` must hold an even count of ones. A captured beat with any failing byte drives `perr_n` low for exactly the second clock after its ready edge. Failing beats at consecutive clocks give consecutive low clocks.
- R10: During reset and right after it, `req_ready` = 1, `bus_start_n` = 1, `bus_cache_req_n` = 1, `perr_n` = 1 and `line_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Line fill request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | 32 | Line fill address |
| req_pwt | input | 1 | Page write-through bit for this fill |
| bus_start_n | output | 1 | Active-low address/cycle start strobe |
| bus_addr | output | 32 | Bus address, held for the cycle |
| bus_cache_req_n | output | 1 | Active-low cache-request (line fill) output |
| bus_rdy_n | input | 1 | Active-low beat ready |
| bus_cacheable_n | input | 1 | Active-low cacheability, sampled at first ready |
| bus_wbpol | input | 1 | Write policy, 1 = writeback, sampled at first ready |
| bus_data | input | 64 | Read data beat |
| bus_dpar | input | 8 | Even parity, one bit per data byte |
| perr_n | output | 1 | Active-low parity error pulse |
| line_valid | output | 1 | Line strobe, one clock |
| line_data | output | 256 | Assembled line, four slots |
| line_single | output | 1 | Line came from a single transfer |
| line_excl | output | 1 | Line policy: 1 exclusive, 0 shared |

## Verification
The parity report for a beat arrives two clocks late, so it can overlap unrelated activity. The report for the last beat of a fill falls in the address clock of the next fill when that next request is offered in the same clock as the line strobe. A test ends a burst on a bad beat and issues the next request at once. It then checks that the parity pulse appears in the same clock as the start strobe, with neither corrupted. A second overlap sets two adjacent bad beats inside a burst with no wait states. Each parity pulse then lands while a later beat is being captured. A clock-by-clock model in the bench, driven only by which beats it sent with bad parity, judges the error output on every clock.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_WAIT1 = 2'd2,
    ST_BURST = 2'd3
  } bstate_t;

  // Even parity over one byte plus its parity bit: 1 when the pair fails.
  function automatic logic byte_par_fail(input logic [7:0] b, input logic p);
    return ^{b, p};
  endfunction
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int BEATS = 4,
  parameter int IDXW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            rdy_n,
  input  logic            cacheable_n,
  output bstate_t         state,
  output logic            cap,
  output logic            first_cap,
  output logic            last_cap,
  output logic [IDXW-1:0] beat_idx
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(BEATS - 1);

  logic [IDXW-1:0] cnt;

  always_comb begin
    cap       = ((state == ST_WAIT1) || (state == ST_BURST)) && !rdy_n;
    first_cap = cap && (state == ST_WAIT1);
    beat_idx  = (state == ST_WAIT1) ? '0 : cnt;
    last_cap  = cap && (((state == ST_WAIT1) && cacheable_n) ||
                        ((state == ST_BURST) && (cnt == LAST_IDX)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE:  if (accept) state <= ST_ADDR;
        ST_ADDR:  state <= ST_WAIT1;
        ST_WAIT1: begin
          if (cap) begin
            if (cacheable_n) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_BURST;
              cnt   <= IDXW'(1);
            end
          end
        end
        ST_BURST: begin
          if (cap) begin
            cnt <= cnt + IDXW'(1);
            if (cnt == LAST_IDX) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/par_check.sv
module par_check
  import burst_pkg::*;
#(
  parameter int DW    = 64,
  parameter int NB    = 8,
  parameter int DELAY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] data,
  input  logic [NB-1:0] par,
  output logic          perr_n
);
  logic [NB-1:0]    fail;
  logic [DELAY-1:0] sh;
  logic             bad;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign fail[g] = byte_par_fail(data[g*8 +: 8], par[g]);
  end

  assign bad = cap && (|fail);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0;
    end else begin
      sh[0] <= bad;
      for (int i = 1; i < DELAY; i++) sh[i] <= sh[i-1];
    end
  end

  assign perr_n = !sh[DELAY-1];
endmodule

// File: rtl/line_asm.sv
module line_asm #(
  parameter int DW    = 64,
  parameter int BEATS = 4,
  parameter int IDXW  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [IDXW-1:0]     start_idx,
  input  logic                pwt,
  input  logic                cap,
  input  logic                first_cap,
  input  logic                last_cap,
  input  logic [IDXW-1:0]     beat_idx,
  input  logic [DW-1:0]       data,
  input  logic                cacheable_n,
  input  logic                wbpol,
  output logic                line_valid,
  output logic [BEATS*DW-1:0] line_data,
  output logic                line_single,
  output logic                line_excl
);
  logic [IDXW-1:0] start_q;
  logic            pwt_q;
  logic [IDXW-1:0] dest;

  assign dest = start_q ^ beat_idx;

  for (genvar g = 0; g < BEATS; g++) begin : g_slot
    logic [DW-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                 slot_q <= '0;
      else if (accept)                            slot_q <= '0;
      else if (cap && (dest == IDXW'(g)))         slot_q <= data;
    end
    assign line_data[g*DW +: DW] = slot_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q     <= '0;
      pwt_q       <= 1'b0;
      line_valid  <= 1'b0;
      line_single <= 1'b0;
      line_excl   <= 1'b0;
    end else begin
      line_valid <= last_cap;
      if (accept) begin
        start_q <= start_idx;
        pwt_q   <= pwt;
      end
      if (first_cap) begin
        line_single <= cacheable_n;
        line_excl   <= wbpol && !pwt_q;
      end
    end
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int BEATS = 4,
  parameter int PERR_DELAY = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [AW-1:0]       req_addr,
  input  logic                req_pwt,
  output logic                bus_start_n,
  output logic [AW-1:0]       bus_addr,
  output logic                bus_cache_req_n,
  input  logic                bus_rdy_n,
  input  logic                bus_cacheable_n,
  input  logic                bus_wbpol,
  input  logic [DW-1:0]       bus_data,
  input  logic [DW/8-1:0]     bus_dpar,
  output logic                perr_n,
  output logic                line_valid,
  output logic [BEATS*DW-1:0] line_data,
  output logic                line_single,
  output logic                line_excl
);
  localparam int NB   = DW / 8;
  localparam int OFFW = $clog2(NB);
  localparam int IDXW = $clog2(BEATS);

  bstate_t         state;
  logic            accept, cap, first_cap, last_cap;
  logic [IDXW-1:0] beat_idx;
  logic [AW-1:0]   addr_q;

  assign req_ready       = (state == ST_IDLE);
  assign accept          = req_valid && req_ready;
  assign bus_start_n     = !(state == ST_ADDR);
  assign bus_cache_req_n = !(state == ST_ADDR);
  assign bus_addr        = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  burst_ctrl #(.BEATS(BEATS), .IDXW(IDXW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .rdy_n(bus_rdy_n),
    .cacheable_n(bus_cacheable_n), .state(state), .cap(cap),
    .first_cap(first_cap), .last_cap(last_cap), .beat_idx(beat_idx)
  );

  par_check #(.DW(DW), .NB(NB), .DELAY(PERR_DELAY)) u_par (
    .clk(clk), .rst_n(rst_n), .cap(cap), .data(bus_data),
    .par(bus_dpar), .perr_n(perr_n)
  );

  line_asm #(.DW(DW), .BEATS(BEATS), .IDXW(IDXW)) u_line (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .start_idx(req_addr[OFFW +: IDXW]), .pwt(req_pwt), .cap(cap),
    .first_cap(first_cap), .last_cap(last_cap), .beat_idx(beat_idx),
    .data(bus_data), .cacheable_n(bus_cacheable_n), .wbpol(bus_wbpol),
    .line_valid(line_valid), .line_data(line_data),
    .line_single(line_single), .line_excl(line_excl)
  );
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          bus_start_n,
  input logic          bus_cache_req_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rdy_n,
  input logic          perr_n,
  input logic          line_valid
);
  assert_t1_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (!bus_start_n && !bus_cache_req_n && bus_addr == $past(req_addr)));

  assert_t1_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_start_n |=> bus_start_n);

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> $stable(bus_addr));

  assert_no_early_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_start_n |=> (!line_valid && !req_ready));

  assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |=> !line_valid);

  assert_strobe_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> req_ready);

  assert_perr_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> $past(!bus_rdy_n, 2));
endmodule

bind burst_seq burst_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .bus_start_n(bus_start_n),
  .bus_cache_req_n(bus_cache_req_n), .bus_addr(bus_addr),
  .bus_rdy_n(bus_rdy_n), .perr_n(perr_n), .line_valid(line_valid)
);

// File: tb/sim_burst_seq.sv
`timescale 1ns/1ps
module sim_burst_seq;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_addr = '0;
  logic         req_pwt = 1'b0;
  logic         bus_start_n, bus_cache_req_n;
  logic [31:0]  bus_addr;
  logic         bus_rdy_n = 1'b1;
  logic         bus_cacheable_n = 1'b1;
  logic         bus_wbpol = 1'b0;
  logic [63:0]  bus_data = '0;
  logic [7:0]   bus_dpar = '0;
  logic         perr_n, line_valid, line_single, line_excl;
  logic [255:0] line_data;

  int checks = 0;
  int fails  = 0;
  logic bad_drv = 1'b0;
  logic p1 = 1'b0, p2 = 1'b0;
  logic mon_on = 1'b0;

  always #5 clk = ~clk;

  burst_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_pwt(req_pwt), .bus_start_n(bus_start_n),
    .bus_addr(bus_addr), .bus_cache_req_n(bus_cache_req_n),
    .bus_rdy_n(bus_rdy_n), .bus_cacheable_n(bus_cacheable_n),
    .bus_wbpol(bus_wbpol), .bus_data(bus_data), .bus_dpar(bus_dpar),
    .perr_n(perr_n), .line_valid(line_valid), .line_data(line_data),
    .line_single(line_single), .line_excl(line_excl)
  );

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // R9 reference: a bad beat sent at an edge shows as perr_n low two clocks later.
  always @(posedge clk) begin
    if (!rst_n) begin p1 <= 1'b0; p2 <= 1'b0; end
    else begin p1 <= bad_drv; p2 <= p1; end
  end
  always @(negedge clk) if (mon_on) chk("R9 perr_n timing", 256'(perr_n), 256'(!p2));

  function automatic logic [63:0] beat_val(input logic [31:0] a, input int k);
    return {a, 24'h5A3C00, 8'(k)} ^ {8'(k * 17), 56'h0};
  endfunction

  function automatic logic [7:0] even_par(input logic [63:0] d, input logic bad);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = ^d[i*8 +: 8];
    if (bad) p[0] = ~p[0];
    return p;
  endfunction

  // One fill. waits: 4 bits per beat (beat k at [4k+:4]); bad: per-beat parity error.
  task automatic fill(input string name, input logic [31:0] a, input logic pwt,
                      input logic cach, input logic wb, input logic [15:0] waits,
                      input logic [3:0] bad, input logic t1rdy, input logic nowait);
    logic [255:0] exp;
    logic [1:0]   s;
    int           nb;
    exp = '0;
    s   = a[4:3];
    nb  = cach ? 4 : 1;
    if (!nowait) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_pwt = pwt;
    chk({name, " R1 req_ready idle"}, 256'(req_ready), 256'(1));
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_pwt = ~pwt;
    chk({name, " R1 start_n"}, 256'(bus_start_n), 256'(0));
    chk({name, " R1 cache_req_n"}, 256'(bus_cache_req_n), 256'(0));
    chk({name, " R1 bus_addr"}, 256'(bus_addr), 256'(a));
    chk({name, " R1 busy"}, 256'(req_ready), 256'(0));
    chk({name, " R7 strobe low in T1"}, 256'(line_valid), 256'(0));
    if (t1rdy) begin
      bus_rdy_n = 1'b0; bus_cacheable_n = 1'b1;
      bus_data = 64'hDEAD_BEEF_0BAD_F00D;
      bus_dpar = even_par(bus_data, 1'b1);
    end
    for (int k = 0; k < nb; k++) begin
      for (int w = 0; w < int'(waits[k*4 +: 4]); w++) begin
        @(negedge clk);
        bus_rdy_n = 1'b1; bad_drv = 1'b0;
        chk({name, " R2 addr hold"}, 256'(bus_addr), 256'(a));
        chk({name, " R3 wait no strobe"}, 256'(line_valid), 256'(0));
      end
      @(negedge clk);
      chk({name, " R2 addr hold"}, 256'(bus_addr), 256'(a));
      chk({name, " R1 start_n high"}, 256'(bus_start_n), 256'(1));
      bus_rdy_n = 1'b0;
      bus_data = beat_val(a, k);
      bus_dpar = even_par(bus_data, bad[k]);
      bad_drv = bad[k];
      bus_cacheable_n = (k == 0) ? !cach : 1'b1;  // R5: later values ignored
      bus_wbpol = (k == 0) ? wb : !wb;           // R8: later values ignored
      exp[64*(s ^ 2'(k)) +: 64] = beat_val(a, k);
    end
    @(negedge clk);
    bus_rdy_n = 1'b1; bad_drv = 1'b0; bus_cacheable_n = 1'b1;
    chk({name, " R7 line_valid"}, 256'(line_valid), 256'(1));
    chk({name, " R7 ready with strobe"}, 256'(req_ready), 256'(1));
    chk({name, " R6 line_data"}, line_data, exp);
    chk({name, " R4 line_single"}, 256'(line_single), 256'(!cach));
    chk({name, " R8 line_excl"}, 256'(line_excl), 256'(wb && !pwt));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 req_ready", 256'(req_ready), 256'(1));
    chk("R10 start_n", 256'(bus_start_n), 256'(1));
    chk("R10 cache_req_n", 256'(bus_cache_req_n), 256'(1));
    chk("R10 perr_n", 256'(perr_n), 256'(1));
    chk("R10 line_valid", 256'(line_valid), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle after reset", 256'(req_ready), 256'(1));
    mon_on = 1'b1;
  endtask

  task automatic t_burst_fast();   // R5 R6 R8: 2-1-1-1, start slot 0, exclusive
    fill("burst_fast", 32'h0000_1000, 1'b0, 1'b1, 1'b1, 16'h0000, 4'b0000, 1'b0, 1'b0);
  endtask

  task automatic t_burst_waits();  // R3 R6 R8: waits, ready in T1 ignored, pwt -> shared
    fill("burst_waits", 32'h0000_2010, 1'b1, 1'b1, 1'b1, 16'h1023, 4'b0000, 1'b1, 1'b0);
  endtask

  task automatic t_single();       // R4: cacheability negated, slot 3
    fill("single", 32'h0000_3018, 1'b0, 1'b0, 1'b1, 16'h0001, 4'b0000, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk("single R4 no extra strobe", 256'(line_valid), 256'(0));
  endtask

  task automatic t_parity_adjacent(); // R9: beats 1 and 2 bad back-to-back, writethrough
    fill("par_adj", 32'h0000_4008, 1'b0, 1'b1, 1'b0, 16'h0000, 4'b0110, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_overlap();      // R9 R1: last-beat error lands in next fill's T1
    fill("ovl_a", 32'h0000_5000, 1'b0, 1'b1, 1'b1, 16'h2100, 4'b1000, 1'b0, 1'b0);
    fill("ovl_b", 32'h0000_6018, 1'b0, 1'b1, 1'b1, 16'h0000, 4'b0001, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_burst_fast();
        t_burst_waits();
        t_single();
        t_parity_adjacent();
        t_overlap();
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    mon_on = 1'b0;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule